// File: doc/BRIEF.md
# Blocking Fully-Associative Write-Back Cache

This block is a small cache that sits between one upstream requester and a memory port and works on one request at a time. An accepted request is held while its tag lookup waits a fixed number of cycles. A hit is served from the line array: a read returns the addressed bytes and a write merges its bytes into the line. A miss goes to memory. A line-aligned access of exactly one line is sent to memory as it is. Any narrower access becomes a full-line read, and the original access is applied to the line when the fill returns.

The line array is fully associative. A free line is used while one exists. Once every line is valid, a victim is picked from a free-running LFSR. The victim is always written back to memory before the fill is requested, because the cache keeps no dirty bit. While the cache is busy the requester sees `req_ready` low, and a request offered then is dropped. The requester must offer it again later. Hit and miss counts, and the latency of the last miss, are kept as outputs.

Control is one state machine with five states. ST_IDLE accepts a request and moves to ST_LOOKUP. ST_LOOKUP waits out the lookup latency and then has four exits. It returns to ST_IDLE with a response on a hit or on an illegal access. It goes to ST_WB on a miss when every line is valid. It goes to ST_FILL on a miss when a line is free. ST_WB moves to ST_FILL once memory accepts the writeback. ST_FILL moves to ST_WAIT once memory accepts the line request. ST_WAIT returns to ST_IDLE when the memory response arrives, and the line is installed and the response issued in that same edge.

Top module: `blk_wb_cache`

## Requirements
- R1: `req_ready` is high only in the idle state. A request offered while `req_ready` is low is dropped. It causes no response and no memory traffic, and it does not change the counters.
- R2: `rsp_id` carries the `req_id` captured when the request was accepted.
- R3: A hit responds exactly LOOKUP_LAT cycles after the accepting edge and issues no memory request. A read returns the bytes of lanes offset to offset+size-1 of the line in those lanes of `rsp_rdata` and zeros in every other lane. Lane k is bits 8k+7:8k, and the offset is the low address bits inside the line.
- R4: A write takes its bytes from the same lanes of `req_wdata` and merges only those lanes into the line. Other lanes keep their value, and a write response carries all-zero `rsp_rdata`.
- R5: A miss with offset 0 and size equal to LINE_BYTES is sent to memory unchanged. A read goes out with `mem_req_write`=0. A write goes out with `mem_req_write`=1, `mem_req_evict`=0 and the request's full `req_wdata`.
- R6: Any other legal miss issues one full-line read (`mem_req_write`=0) at the line-aligned address. The original read or write is applied to the returned line, and the response appears in the same edge that samples `mem_rsp_valid`.
- R7: A size of 0, or an offset+size greater than LINE_BYTES, gives a response with `rsp_err`=1 exactly LOOKUP_LAT cycles after acceptance. Such a request causes no memory traffic and no counter change.
- R8: A writeback (`mem_req_write`=1, `mem_req_evict`=1) is issued only when every line is valid. It carries the address and the current contents of a resident line.
- R9: In the cycle where `rsp_valid` is high, `req_ready` is already high, so a new request can be accepted on the next edge.
- R10: `hit_cnt` increments once per hit and `miss_cnt` increments once per legal miss. Both change in the edge that raises the matching response (for a miss, `miss_cnt` changes at detection).
- R11: `miss_lat` gives the number of clock edges from the miss-detection edge (LOOKUP_LAT after acceptance) to the edge that samples the fill response.
- R12: A memory request that is not accepted stays valid with stable address, kind and data. A writeback is always accepted before the fill request that follows it.
- R13: After reset `req_ready`=1, `rsp_valid`=0, `mem_req_valid`=0 and both counters are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Upstream request offered |
| req_ready | output | 1 | Cache idle; a request offered now is accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_size | input | OFF_W+1 | Access size in bytes |
| req_wdata | input | LINE_BYTES*8 | Write bytes placed in their byte lanes |
| req_id | input | ID_W | Requester index |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_err | output | 1 | Access crossed a line or had size 0 |
| rsp_id | output | ID_W | Requester index of the response |
| rsp_rdata | output | LINE_BYTES*8 | Read bytes in their lanes, others zero |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | 1 = write to memory |
| mem_req_evict | output | 1 | Writeback of an evicted line; no response follows |
| mem_req_addr | output | ADDR_W | Line-aligned memory address |
| mem_req_wdata | output | LINE_BYTES*8 | Line data for writes |
| mem_rsp_valid | input | 1 | Memory response for a non-evict request |
| mem_rsp_rdata | input | LINE_BYTES*8 | Line data of the response |
| hit_cnt | output | CNT_W | Hit count |
| miss_cnt | output | CNT_W | Miss count |
| miss_lat | output | CNT_W | Latency of the last miss in cycles |

## Verification
Hits and illegal accesses respond exactly LOOKUP_LAT edges after the accepting edge. The bench records that edge number when it drives a request and compares it with the edge at which it first sees `rsp_valid`. A miss responds in the edge that samples the fill, and the bench's memory model notes that edge when it drives `mem_rsp_valid`. The same edge number gives the expected `miss_lat`, and the counters are compared in the response cycle. All outputs are sampled at the falling edge. Memory handshakes are judged at the falling edge before the rising edge that completes them, and residency is tracked only from the writebacks and fills seen at the memory port.

// File: rtl/blk_wb_cache_pkg.sv
package blk_wb_cache_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_WB,
        ST_FILL,
        ST_WAIT
    } cache_state_e;

endpackage

// File: rtl/bwc_victim_lfsr.sv
module bwc_victim_lfsr #(
    parameter int          NUM_LINES = 4,
    parameter int          LFSR_W    = 8,
    parameter logic [7:0]  SEED      = 8'h5A,
    parameter logic [7:0]  TAPS      = 8'hB8,
    localparam int         WAY_W     = $clog2(NUM_LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [WAY_W-1:0] way
);

    logic [LFSR_W-1:0] lfsr_q;

    // Galois form, stepping on every clock
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lfsr_q <= SEED[LFSR_W-1:0];
        end else if (lfsr_q[0]) begin
            lfsr_q <= (lfsr_q >> 1) ^ TAPS[LFSR_W-1:0];
        end else begin
            lfsr_q <= lfsr_q >> 1;
        end
    end

    assign way = lfsr_q[WAY_W-1:0];

endmodule

// File: rtl/bwc_line_store.sv
module bwc_line_store #(
    parameter int  NUM_LINES = 4,
    parameter int  TAG_W     = 5,
    parameter int  LINE_W    = 64,
    localparam int WAY_W     = $clog2(NUM_LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TAG_W-1:0]  lk_tag,
    output logic              lk_hit,
    output logic [WAY_W-1:0]  lk_way,
    output logic [LINE_W-1:0] lk_data,
    output logic              all_valid,
    output logic [WAY_W-1:0]  free_way,
    input  logic [WAY_W-1:0]  vic_way,
    output logic [TAG_W-1:0]  vic_tag,
    output logic [LINE_W-1:0] vic_data,
    input  logic              wr_en,
    input  logic [WAY_W-1:0]  wr_way,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [LINE_W-1:0] wr_data
);

    logic [NUM_LINES-1:0] valid_q;
    logic [TAG_W-1:0]     tag_q  [NUM_LINES];
    logic [LINE_W-1:0]    data_q [NUM_LINES];
    logic [NUM_LINES-1:0] match;

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        assign match[g] = valid_q[g] && (tag_q[g] == lk_tag);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                valid_q[g] <= 1'b0;
            end else if (wr_en && (wr_way == WAY_W'(g))) begin
                valid_q[g] <= 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (wr_en && (wr_way == WAY_W'(g))) begin
                tag_q[g]  <= wr_tag;
                data_q[g] <= wr_data;
            end
        end
    end

    always_comb begin
        lk_way   = '0;
        free_way = '0;
        for (int i = NUM_LINES - 1; i >= 0; i--) begin
            if (match[i]) begin
                lk_way = WAY_W'(i);
            end
            if (!valid_q[i]) begin
                free_way = WAY_W'(i);
            end
        end
    end

    assign lk_hit    = |match;
    assign all_valid = &valid_q;
    assign lk_data   = data_q[lk_way];
    assign vic_tag   = tag_q[vic_way];
    assign vic_data  = data_q[vic_way];

endmodule

// File: rtl/blk_wb_cache.sv
module blk_wb_cache
    import blk_wb_cache_pkg::*;
#(
    parameter int  ADDR_W     = 8,
    parameter int  LINE_BYTES = 8,
    parameter int  NUM_LINES  = 4,
    parameter int  LOOKUP_LAT = 2,
    parameter int  ID_W       = 2,
    parameter int  CNT_W      = 16,
    localparam int OFF_W      = $clog2(LINE_BYTES),
    localparam int SIZE_W     = OFF_W + 1,
    localparam int LINE_W     = LINE_BYTES * 8,
    localparam int TAG_W      = ADDR_W - OFF_W,
    localparam int WAY_W      = $clog2(NUM_LINES),
    localparam int LAT_W      = $clog2(LOOKUP_LAT + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [SIZE_W-1:0] req_size,
    input  logic [LINE_W-1:0] req_wdata,
    input  logic [ID_W-1:0]   req_id,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [ID_W-1:0]   rsp_id,
    output logic [LINE_W-1:0] rsp_rdata,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic              mem_req_write,
    output logic              mem_req_evict,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [LINE_W-1:0] mem_req_wdata,
    input  logic              mem_rsp_valid,
    input  logic [LINE_W-1:0] mem_rsp_rdata,
    output logic [CNT_W-1:0]  hit_cnt,
    output logic [CNT_W-1:0]  miss_cnt,
    output logic [CNT_W-1:0]  miss_lat
);

    function automatic logic [LINE_BYTES-1:0] lane_mask(
        input logic [OFF_W-1:0] off, input logic [SIZE_W-1:0] size);
        logic [LINE_BYTES-1:0] m;
        for (int b = 0; b < LINE_BYTES; b++) begin
            m[b] = (b >= int'(off)) && (b < int'(off) + int'(size));
        end
        return m;
    endfunction

    function automatic logic [LINE_W-1:0] lane_merge(
        input logic [LINE_W-1:0] old, input logic [LINE_W-1:0] nw,
        input logic [LINE_BYTES-1:0] m);
        logic [LINE_W-1:0] r;
        for (int b = 0; b < LINE_BYTES; b++) begin
            r[b*8 +: 8] = m[b] ? nw[b*8 +: 8] : old[b*8 +: 8];
        end
        return r;
    endfunction

    function automatic logic [LINE_W-1:0] lane_pick(
        input logic [LINE_W-1:0] line, input logic [LINE_BYTES-1:0] m);
        logic [LINE_W-1:0] r;
        for (int b = 0; b < LINE_BYTES; b++) begin
            r[b*8 +: 8] = m[b] ? line[b*8 +: 8] : 8'h00;
        end
        return r;
    endfunction

    cache_state_e state_q, state_d;

    // Saved request
    logic              s_write;
    logic [ADDR_W-1:0] s_addr;
    logic [SIZE_W-1:0] s_size;
    logic [LINE_W-1:0] s_wdata;
    logic [ID_W-1:0]   s_id;
    logic [LAT_W-1:0]  lat_q;
    logic [WAY_W-1:0]  victim_q;
    logic [CNT_W-1:0]  mlat_q;

    logic [OFF_W-1:0]      s_off;
    logic [TAG_W-1:0]      s_tag;
    logic [LINE_BYTES-1:0] s_mask;
    logic                  s_bad;
    logic                  s_full;
    logic                  lookup_done;

    // Line store and victim picker
    logic              lk_hit, all_valid, st_wr_en;
    logic [WAY_W-1:0]  lk_way, free_way, lfsr_way, st_wr_way;
    logic [LINE_W-1:0] lk_data, vic_data, st_wr_data, fill_line;
    logic [TAG_W-1:0]  vic_tag;

    assign s_off       = s_addr[OFF_W-1:0];
    assign s_tag       = s_addr[ADDR_W-1:OFF_W];
    assign s_mask      = lane_mask(s_off, s_size);
    assign s_bad       = (s_size == '0) || (int'(s_off) + int'(s_size) > LINE_BYTES);
    assign s_full      = (s_off == '0) && (int'(s_size) == LINE_BYTES);
    assign lookup_done = (state_q == ST_LOOKUP) && (lat_q == LAT_W'(LOOKUP_LAT - 1));
    assign fill_line   = s_write ? lane_merge(mem_rsp_rdata, s_wdata, s_mask) : mem_rsp_rdata;

    bwc_line_store #(
        .NUM_LINES (NUM_LINES),
        .TAG_W     (TAG_W),
        .LINE_W    (LINE_W)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .lk_tag    (s_tag),
        .lk_hit    (lk_hit),
        .lk_way    (lk_way),
        .lk_data   (lk_data),
        .all_valid (all_valid),
        .free_way  (free_way),
        .vic_way   (victim_q),
        .vic_tag   (vic_tag),
        .vic_data  (vic_data),
        .wr_en     (st_wr_en),
        .wr_way    (st_wr_way),
        .wr_tag    (s_tag),
        .wr_data   (st_wr_data)
    );

    bwc_victim_lfsr #(
        .NUM_LINES (NUM_LINES)
    ) u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .way   (lfsr_way)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_valid) state_d = ST_LOOKUP;
            ST_LOOKUP: if (lookup_done) begin
                           if (s_bad || lk_hit) state_d = ST_IDLE;
                           else if (all_valid)  state_d = ST_WB;
                           else                 state_d = ST_FILL;
                       end
            ST_WB:     if (mem_req_ready) state_d = ST_FILL;
            ST_FILL:   if (mem_req_ready) state_d = ST_WAIT;
            ST_WAIT:   if (mem_rsp_valid) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Outputs and store write port
    always_comb begin
        req_ready     = (state_q == ST_IDLE);
        mem_req_valid = (state_q == ST_WB) || (state_q == ST_FILL);
        mem_req_evict = (state_q == ST_WB);
        mem_req_write = (state_q == ST_WB) || (s_write && s_full);
        mem_req_addr  = (state_q == ST_WB) ? {vic_tag, {OFF_W{1'b0}}} : {s_tag, {OFF_W{1'b0}}};
        mem_req_wdata = (state_q == ST_WB) ? vic_data : s_wdata;
        st_wr_en      = (lookup_done && !s_bad && lk_hit && s_write) ||
                        ((state_q == ST_WAIT) && mem_rsp_valid);
        st_wr_way     = (state_q == ST_WAIT) ? victim_q : lk_way;
        st_wr_data    = (state_q == ST_WAIT) ? fill_line : lane_merge(lk_data, s_wdata, s_mask);
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_write   <= 1'b0;
            s_addr    <= '0;
            s_size    <= '0;
            s_wdata   <= '0;
            s_id      <= '0;
            lat_q     <= '0;
            victim_q  <= '0;
            mlat_q    <= '0;
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_id    <= '0;
            rsp_rdata <= '0;
            hit_cnt   <= '0;
            miss_cnt  <= '0;
            miss_lat  <= '0;
        end else begin
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        s_write <= req_write;
                        s_addr  <= req_addr;
                        s_size  <= req_size;
                        s_wdata <= req_wdata;
                        s_id    <= req_id;
                        lat_q   <= '0;
                    end
                end
                ST_LOOKUP: begin
                    lat_q <= lat_q + 1'b1;
                    if (lookup_done) begin
                        if (s_bad) begin
                            rsp_valid <= 1'b1;
                            rsp_err   <= 1'b1;
                            rsp_id    <= s_id;
                            rsp_rdata <= '0;
                            s_id      <= '0;
                        end else if (lk_hit) begin
                            rsp_valid <= 1'b1;
                            rsp_id    <= s_id;
                            rsp_rdata <= s_write ? '0 : lane_pick(lk_data, s_mask);
                            s_id      <= '0;
                            hit_cnt   <= hit_cnt + 1'b1;
                        end else begin
                            miss_cnt  <= miss_cnt + 1'b1;
                            victim_q  <= all_valid ? lfsr_way : free_way;
                            mlat_q    <= CNT_W'(1);
                        end
                    end
                end
                ST_WB, ST_FILL: begin
                    mlat_q <= mlat_q + 1'b1;
                end
                ST_WAIT: begin
                    if (mem_rsp_valid) begin
                        rsp_valid <= 1'b1;
                        rsp_id    <= s_id;
                        rsp_rdata <= s_write ? '0 : lane_pick(mem_rsp_rdata, s_mask);
                        s_id      <= '0;
                        miss_lat  <= mlat_q;
                    end else begin
                        mlat_q <= mlat_q + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/blk_wb_cache_chk.sv
module blk_wb_cache_chk #(
    parameter int  ADDR_W     = 8,
    parameter int  LINE_BYTES = 8,
    parameter int  CNT_W      = 16,
    localparam int OFF_W      = $clog2(LINE_BYTES),
    localparam int LINE_W     = LINE_BYTES * 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic              rsp_err,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic              mem_req_write,
    input logic              mem_req_evict,
    input logic [ADDR_W-1:0] mem_req_addr,
    input logic [LINE_W-1:0] mem_req_wdata,
    input logic [CNT_W-1:0]  hit_cnt
);

    // R1
    accept_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R1
    idle_no_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !mem_req_valid);

    // R9
    release_with_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> req_ready);

    // R3
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R7
    err_with_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> rsp_valid);

    // R6
    mem_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (mem_req_addr[OFF_W-1:0] == '0));

    // R8
    evict_is_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_evict) |-> mem_req_write);

    // R12
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=>
        (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write) &&
         $stable(mem_req_evict) && $stable(mem_req_wdata)));

    // R10
    hit_count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_cnt != $past(hit_cnt)) |-> (rsp_valid && !rsp_err && (hit_cnt == $past(hit_cnt) + 1'b1)));

endmodule

bind blk_wb_cache blk_wb_cache_chk #(
    .ADDR_W     (ADDR_W),
    .LINE_BYTES (LINE_BYTES),
    .CNT_W      (CNT_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .rsp_valid     (rsp_valid),
    .rsp_err       (rsp_err),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_write (mem_req_write),
    .mem_req_evict (mem_req_evict),
    .mem_req_addr  (mem_req_addr),
    .mem_req_wdata (mem_req_wdata),
    .hit_cnt       (hit_cnt)
);

// File: tb/blk_wb_cache_tb.sv
`timescale 1ns/1ps
module blk_wb_cache_tb;

    localparam int ADDR_W = 8;
    localparam int LB     = 8;
    localparam int NL     = 4;
    localparam int LAT    = 2;
    localparam int ID_W   = 2;
    localparam int CNT_W  = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic        req_ready;
    logic [7:0]  req_addr = '0;
    logic [3:0]  req_size = '0;
    logic [63:0] req_wdata = '0;
    logic [1:0]  req_id = '0;
    logic        rsp_valid, rsp_err;
    logic [1:0]  rsp_id;
    logic [63:0] rsp_rdata;
    logic        mem_req_valid, mem_req_write, mem_req_evict;
    logic        mem_req_ready = 1'b0;
    logic [7:0]  mem_req_addr;
    logic [63:0] mem_req_wdata;
    logic        mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_rdata = '0;
    logic [15:0] hit_cnt, miss_cnt, miss_lat;

    always #5 clk = ~clk;

    blk_wb_cache #(
        .ADDR_W(ADDR_W), .LINE_BYTES(LB), .NUM_LINES(NL),
        .LOOKUP_LAT(LAT), .ID_W(ID_W), .CNT_W(CNT_W)
    ) u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata), .req_id(req_id),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_id(rsp_id), .rsp_rdata(rsp_rdata),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_write(mem_req_write), .mem_req_evict(mem_req_evict),
        .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata),
        .hit_cnt(hit_cnt), .miss_cnt(miss_cnt), .miss_lat(miss_lat)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int checks = 0, errors = 0;
    bit done = 1'b0;

    logic [7:0] gold [256];
    logic [7:0] memb [256];
    bit   resident [32];
    int   res_count = 0;
    int   exp_hits = 0, exp_misses = 0;

    // memory-side observations for the request in progress
    int          n_fill = 0, n_wb = 0;
    bit          f_write;
    logic [7:0]  f_addr;
    logic [63:0] f_data;
    int          rsp_edge = 0;
    int          rsp_cnt = 0;
    logic [7:0]  rsp_addr;
    bit          stall_mode = 1'b0;
    bit          stalled = 1'b0;
    logic [7:0]  st_addr;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] gline(input int ln);
        logic [63:0] r;
        for (int b = 0; b < LB; b++) r[b*8 +: 8] = gold[ln*LB + b];
        return r;
    endfunction

    function automatic logic [63:0] mline(input int ln);
        logic [63:0] r;
        for (int b = 0; b < LB; b++) r[b*8 +: 8] = memb[ln*LB + b];
        return r;
    endfunction

    // memory model
    initial begin
        forever begin
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            if (rsp_cnt > 0) begin
                rsp_cnt--;
                if (rsp_cnt == 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_rdata = mline(int'(rsp_addr[7:3]));
                    rsp_edge      = cyc + 1;
                end
            end
            if (stalled)
                chk(mem_req_valid && (mem_req_addr == st_addr), "R12 stalled request held",
                    {56'd0, mem_req_addr}, {56'd0, st_addr});
            mem_req_ready = stall_mode ? (($urandom % 3) != 0) : 1'b1;
            #1;
            stalled = mem_req_valid && !mem_req_ready;
            st_addr = mem_req_addr;
            if (mem_req_valid && mem_req_ready) begin
                automatic int ln = int'(mem_req_addr[7:3]);
                if (mem_req_evict) begin
                    n_wb++;
                    chk(res_count == NL, "R8 writeback only when full", 64'(res_count), 64'(NL));
                    chk(resident[ln], "R8 writeback of resident line", 64'(resident[ln]), 64'd1);
                    chk(mem_req_wdata == gline(ln), "R8 writeback data", mem_req_wdata, gline(ln));
                    for (int b = 0; b < LB; b++) memb[ln*LB + b] = mem_req_wdata[b*8 +: 8];
                    resident[ln] = 1'b0;
                    res_count--;
                end else begin
                    n_fill++;
                    chk(res_count < NL, "R12 writeback precedes fill", 64'(res_count), 64'(NL - 1));
                    f_write = mem_req_write;
                    f_addr  = mem_req_addr;
                    f_data  = mem_req_wdata;
                    if (mem_req_write)
                        for (int b = 0; b < LB; b++) memb[ln*LB + b] = mem_req_wdata[b*8 +: 8];
                    resident[ln] = 1'b1;
                    res_count++;
                    rsp_cnt  = 1 + int'($urandom % 3);
                    rsp_addr = mem_req_addr;
                end
            end
        end
    end

    // called at a falling edge; returns at the falling edge that shows the response
    task automatic do_req(input bit w, input logic [7:0] a, input int sz,
                          input logic [63:0] wd, input logic [1:0] id, input bit poke);
        int ln, off, acc, rc, wn;
        bit legal, full, exp_hit;
        logic [63:0] m, exp_rd;
        ln      = int'(a[7:3]);
        off     = int'(a[2:0]);
        legal   = (sz != 0) && (off + sz <= LB);
        full    = (off == 0) && (sz == LB);
        exp_hit = legal && resident[ln];
        m = '0;
        for (int b = 0; b < LB; b++)
            if (legal && b >= off && b < off + sz) m[b*8 +: 8] = 8'hFF;
        exp_rd = w ? 64'd0 : (gline(ln) & m);
        n_fill = 0;
        n_wb   = 0;
        req_valid = 1'b1; req_write = w; req_addr = a;
        req_size = 4'(sz); req_wdata = wd; req_id = id;
        #1;
        while (!req_ready) begin @(negedge clk); #1; end
        acc = cyc + 1;
        @(negedge clk);
        req_valid = 1'b0;
        if (poke) begin
            req_valid = 1'b1; req_id = ~id; req_addr = a ^ 8'h40; req_write = ~w;
            #1;
            chk(!req_ready, "R1 busy refuses", 64'(req_ready), 64'd0);
            @(negedge clk);
            req_valid = 1'b0;
        end
        wn = 0;
        while (!rsp_valid && wn < 200) begin @(negedge clk); wn++; end
        rc = cyc;
        chk(rsp_valid, "R3 response present", 64'(rsp_valid), 64'd1);
        chk(rsp_id == id, "R2 response index", 64'(rsp_id), 64'(id));
        chk(req_ready, "R9 ready with response", 64'(req_ready), 64'd1);
        if (!legal) begin
            chk(rsp_err, "R7 error flag", 64'(rsp_err), 64'd1);
            chk(rc == acc + LAT, "R7 error timing", 64'(rc), 64'(acc + LAT));
            chk(n_fill + n_wb == 0, "R7 no memory traffic", 64'(n_fill + n_wb), 64'd0);
        end else begin
            chk(!rsp_err, "R3 no error", 64'(rsp_err), 64'd0);
            if (exp_hit) begin
                exp_hits++;
                chk(rc == acc + LAT, "R3 hit latency", 64'(rc), 64'(acc + LAT));
                chk(n_fill + n_wb == 0, "R3 hit without memory", 64'(n_fill + n_wb), 64'd0);
            end else begin
                exp_misses++;
                chk(n_fill == 1, "R6 one line request", 64'(n_fill), 64'd1);
                chk(f_addr == (a & 8'hF8), "R6 aligned line address", 64'(f_addr), 64'(a & 8'hF8));
                chk(f_write == (w && full), "R5 request kind", 64'(f_write), 64'(w && full));
                if (w && full) chk(f_data == wd, "R5 forwarded data", f_data, wd);
                chk(rc == rsp_edge, "R6 response at fill edge", 64'(rc), 64'(rsp_edge));
                chk(miss_lat == 16'(rsp_edge - acc - LAT), "R11 miss latency",
                    64'(miss_lat), 64'(rsp_edge - acc - LAT));
            end
            if (w) begin
                chk(rsp_rdata == 64'd0, "R4 write response zero", rsp_rdata, 64'd0);
                for (int b = 0; b < LB; b++)
                    if (b >= off && b < off + sz) gold[ln*LB + b] = wd[b*8 +: 8];
            end else begin
                chk(rsp_rdata == exp_rd, "R3 read data lanes", rsp_rdata, exp_rd);
            end
        end
        chk(hit_cnt == 16'(exp_hits), "R10 hit count", 64'(hit_cnt), 64'(exp_hits));
        chk(miss_cnt == 16'(exp_misses), "R10 miss count", 64'(miss_cnt), 64'(exp_misses));
        if (poke) begin
            @(negedge clk);
            chk(!rsp_valid, "R1 refused request dropped", 64'(rsp_valid), 64'd0);
        end
    endtask

    initial begin
        void'($urandom(32'd1357));
        for (int i = 0; i < 256; i++) begin
            memb[i] = 8'($urandom);
            gold[i] = memb[i];
        end
        for (int i = 0; i < 32; i++) resident[i] = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R13 reset state
        chk(req_ready, "R13 ready after reset", 64'(req_ready), 64'd1);
        chk(!rsp_valid, "R13 no response after reset", 64'(rsp_valid), 64'd0);
        chk(!mem_req_valid, "R13 no memory request after reset", 64'(mem_req_valid), 64'd0);
        chk(hit_cnt == 0 && miss_cnt == 0, "R13 counters zero", {hit_cnt, miss_cnt}, 64'd0);

        // directed corner cases
        do_req(1'b0, 8'h13, 2, 64'd0, 2'd1, 1'b0);                // R6 partial read miss
        do_req(1'b0, 8'h10, 8, 64'd0, 2'd2, 1'b1);                // R3 hit, R1 refusal
        do_req(1'b1, 8'h12, 4, 64'hA1B2_C3D4_E5F6_0718, 2'd3, 1'b0); // R4 write hit
        do_req(1'b0, 8'h10, 8, 64'd0, 2'd0, 1'b0);                // R4 read back
        do_req(1'b1, 8'h2D, 2, 64'h1122_3344_5566_7788, 2'd1, 1'b0); // R6 partial write miss
        do_req(1'b0, 8'h28, 8, 64'd0, 2'd2, 1'b0);
        do_req(1'b1, 8'h38, 8, 64'hDEAD_BEEF_0BAD_F00D, 2'd3, 1'b0); // R5 forwarded write
        do_req(1'b0, 8'h48, 8, 64'd0, 2'd0, 1'b0);                // R5 forwarded read
        do_req(1'b0, 8'h16, 4, 64'd0, 2'd1, 1'b0);                // R7 crossing
        do_req(1'b1, 8'h20, 0, 64'd0, 2'd2, 1'b0);                // R7 size zero
        do_req(1'b0, 8'h61, 1, 64'd0, 2'd3, 1'b0);                // R8 eviction
        do_req(1'b0, 8'h38, 8, 64'd0, 2'd0, 1'b0);

        // constrained random with memory stalls
        stall_mode = 1'b1;
        for (int k = 0; k < 400; k++) begin
            automatic int  sz   = 1 << ($urandom % 4);
            automatic int  ln   = int'($urandom % 8);
            automatic int  off  = (($urandom % 5) == 0) ? int'($urandom % 8)
                                                        : int'(($urandom % (8 / sz)) * sz);
            automatic bit  w    = 1'($urandom);
            automatic bit  poke = (($urandom % 10) == 0);
            do_req(w, 8'(ln * 8 + off), sz, {$urandom, $urandom}, 2'($urandom), poke);
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule